// File: doc/BRIEF.md
# Accelerometer Power-On Configuration Sequencer

This block brings a three-axis SPI accelerometer into a known state after power-on, with no processor involved. A one-cycle start pulse arms it, and the bandwidth and range codes present at that pulse are latched. It then waits a settling delay and runs a fixed list of register steps. It finishes by pulsing done, or pulsing error if a step cannot be completed.

The steps run in this order:
- unlock writes to the sensor;
- soft reset;
- three constant register writes;
- read-modify-write of the bandwidth field;
- read-modify-write of the range field;
- lock writes again;
- a second, longer delay;
- a bracketed unlock, interrupt-enable write and lock.

The sequencer talks to a neighbouring byte-level SPI master. It frames each transaction with its own chip select and issues one byte at a time. For each byte it gets back the received byte and a failure flag. A step whose byte fails is started again from its first transaction. This continues until the step succeeds or the attempt limit is reached.

Top module: `sqc_top`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done and err are 0 and spi_cs_n is 1.
- R2: A register read is one chip-select window of two bytes. The first byte is 1 in bit 7 with the 7-bit address in bits 6:0. The second byte is 0x00, and the byte received during it is taken as the register value.
- R3: A register write is one chip-select window of two bytes. The first byte is 0 in bit 7 with the 7-bit address in bits 6:0, and the second byte is the data.
- R4: spi_byte_start is raised only while spi_cs_n is 0. Between two transactions spi_cs_n stays 1 for at least CS_GAP clock cycles.
- R5: A clean run performs exactly 11 writes, as (address, data) pairs, in this order:
  1. (0x0D, unlock);
  2. (0x10, 0xB6);
  3. (0x35, 0x81);
  4. (0x33, 0x81);
  5. (0x21, 0xFF);
  6. (0x20, bandwidth);
  7. (0x35, range);
  8. (0x0D, lock);
  9. (0x0D, unlock);
  10. (0x21, 0x02);
  11. (0x0D, lock).
- R6: Unlock reads register 0x0D and writes it back with bit 4 set. Lock reads 0x0D and writes it back with bit 4 cleared. All other bits keep the value that was read.
- R7: The bandwidth update reads 0x20 and writes it back with bits 7:4 replaced by bw_code. The range update reads 0x35 and writes it back with bits 3:1 replaced by range_code. All other bits keep the value that was read.
- R8: At least PRE_WAIT clock cycles pass between the accepted start and the first chip-select fall. spi_cs_n stays 1 for at least POST_WAIT cycles between the first lock write and the following unlock read.
- R9: A byte reported with spi_byte_fail ends its transaction, and a failed write byte updates nothing in the sensor. The whole step is then repeated from its first transaction, and the rest of the sequence is unchanged.
- R10: When one step fails MAX_TRIES times in a row, err pulses for one cycle, busy falls, done stays 0, and no further transaction is issued.
- R11: done pulses for exactly one cycle after the final lock write. busy is 1 from the cycle after the accepted start until done or err.
- R12: start, bw_code and range_code are ignored while busy. The field values come from the codes sampled with the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| bw_code | input | 4 | Bandwidth code for the filter field |
| range_code | input | 3 | Full-scale range code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: sequence completed |
| err | output | 1 | One-cycle pulse: attempt limit reached |
| spi_cs_n | output | 1 | Sensor chip select, active low |
| spi_byte_start | output | 1 | One-cycle request to shift spi_byte_tx |
| spi_byte_tx | output | 8 | Byte to transmit |
| spi_byte_done | input | 1 | One-cycle pulse: byte exchange finished |
| spi_byte_fail | input | 1 | Qualifies spi_byte_done: the exchange failed |
| spi_byte_rx | input | 8 | Byte received, valid with spi_byte_done |

## Verification
The embedded properties check several rules on every cycle:
- chip-select framing and the minimum high gap;
- that transactions are issued only to an idle engine;
- that the step index only advances by one or returns to zero;
- that the attempt counter stays within its limit;
- that done and err are exclusive;
- that the latched codes are stable while busy.

Some behaviour only the bench scenarios can show, because it depends on the sensor's register contents:
- the exact order and data of the writes;
- field masking against preset sensor contents;
- the delay lengths;
- whole-step retry after an injected byte failure;
- abandonment after repeated failures.

// File: rtl/sqc_pkg.sv
package sqc_pkg;

    localparam int NUM_STEPS = 13;

    localparam logic [6:0] A_CTRL0  = 7'h0D;
    localparam logic [6:0] A_SRESET = 7'h10;
    localparam logic [6:0] A_OFFS   = 7'h35;
    localparam logic [6:0] A_GAIN   = 7'h33;
    localparam logic [6:0] A_CTRL3  = 7'h21;
    localparam logic [6:0] A_BW     = 7'h20;
    localparam logic [6:0] A_RANGE  = 7'h35;

    localparam logic [7:0] V_SRESET = 8'hB6;
    localparam logic [7:0] V_OFFS   = 8'h81;
    localparam logic [7:0] V_GAIN   = 8'h81;
    localparam logic [7:0] V_CTRL3  = 8'hFF;
    localparam logic [7:0] V_INTEN  = 8'h02;
    localparam logic [7:0] M_WEN    = 8'h10;

    typedef enum logic [1:0] {
        K_WAIT_PRE,
        K_WAIT_POST,
        K_WRITE,
        K_RMW
    } step_kind_e;

    typedef struct packed {
        step_kind_e kind;
        logic [6:0] addr;
        logic [7:0] clr;
        logic [7:0] set;
    } step_t;

endpackage

// File: rtl/sqc_step_rom.sv
module sqc_step_rom
    import sqc_pkg::*;
#(
    parameter int SW     = 4,
    parameter int BW_W   = 4,
    parameter int BW_LSB = 4,
    parameter int RG_W   = 3,
    parameter int RG_LSB = 1
) (
    input  logic [SW-1:0]   idx,
    input  logic [BW_W-1:0] bw,
    input  logic [RG_W-1:0] rng,
    output step_t           stp
);
    localparam logic [7:0] BW_MASK = 8'(((1 << BW_W) - 1) << BW_LSB);
    localparam logic [7:0] RG_MASK = 8'(((1 << RG_W) - 1) << RG_LSB);

    always_comb begin
        stp = '{kind: K_WRITE, addr: 7'h00, clr: 8'h00, set: 8'h00};
        case (idx)
            SW'(0):  stp = '{kind: K_WAIT_PRE,  addr: 7'h00,    clr: 8'h00,    set: 8'h00};
            SW'(1):  stp = '{kind: K_RMW,       addr: A_CTRL0,  clr: M_WEN,    set: M_WEN};
            SW'(2):  stp = '{kind: K_WRITE,     addr: A_SRESET, clr: 8'h00,    set: V_SRESET};
            SW'(3):  stp = '{kind: K_WRITE,     addr: A_OFFS,   clr: 8'h00,    set: V_OFFS};
            SW'(4):  stp = '{kind: K_WRITE,     addr: A_GAIN,   clr: 8'h00,    set: V_GAIN};
            SW'(5):  stp = '{kind: K_WRITE,     addr: A_CTRL3,  clr: 8'h00,    set: V_CTRL3};
            SW'(6):  stp = '{kind: K_RMW,       addr: A_BW,     clr: BW_MASK,
                             set: 8'(8'(bw) << BW_LSB)};
            SW'(7):  stp = '{kind: K_RMW,       addr: A_RANGE,  clr: RG_MASK,
                             set: 8'(8'(rng) << RG_LSB)};
            SW'(8):  stp = '{kind: K_RMW,       addr: A_CTRL0,  clr: M_WEN,    set: 8'h00};
            SW'(9):  stp = '{kind: K_WAIT_POST, addr: 7'h00,    clr: 8'h00,    set: 8'h00};
            SW'(10): stp = '{kind: K_RMW,       addr: A_CTRL0,  clr: M_WEN,    set: M_WEN};
            SW'(11): stp = '{kind: K_WRITE,     addr: A_CTRL3,  clr: 8'h00,    set: V_INTEN};
            SW'(12): stp = '{kind: K_RMW,       addr: A_CTRL0,  clr: M_WEN,    set: 8'h00};
            default: ;
        endcase
    end
endmodule

// File: rtl/sqc_timer.sv
module sqc_timer #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sqc_xfer.sv
module sqc_xfer #(
    parameter int GAP_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       rnw,
    input  logic [6:0] addr,
    input  logic [7:0] wdata,
    output logic       idle,
    output logic       xdone,
    output logic       xfail,
    output logic [7:0] rdata,
    output logic       cs_n,
    output logic       b_start,
    output logic [7:0] b_tx,
    input  logic       b_done,
    input  logic       b_fail,
    input  logic [7:0] b_rx
);
    localparam int GW = $clog2(GAP_CYC + 1) + 1;
    localparam int HW = $clog2(GAP_CYC + 1) + 2;

    typedef enum logic [1:0] { X_IDLE, X_HDR, X_DAT, X_GAP } xst_e;

    typedef struct packed {
        xst_e          st;
        logic          cs_n;
        logic          start;
        logic [7:0]    tx;
        logic          rnw;
        logic [7:0]    wdata;
        logic [7:0]    rdata;
        logic          fail;
        logic          done;
        logic [GW-1:0] cnt;
    } xreg_t;

    xreg_t x_d, x_q;

    always_comb begin
        x_d       = x_q;
        x_d.start = 1'b0;
        x_d.done  = 1'b0;
        case (x_q.st)
            X_IDLE: if (go) begin
                x_d.st    = X_HDR;
                x_d.cs_n  = 1'b0;
                x_d.start = 1'b1;
                x_d.tx    = {rnw, addr};
                x_d.rnw   = rnw;
                x_d.wdata = wdata;
                x_d.fail  = 1'b0;
            end
            X_HDR: if (b_done) begin
                if (b_fail) begin
                    x_d.fail = 1'b1;
                    x_d.cs_n = 1'b1;
                    x_d.cnt  = '0;
                    x_d.st   = X_GAP;
                end else begin
                    x_d.start = 1'b1;
                    x_d.tx    = x_q.rnw ? 8'h00 : x_q.wdata;
                    x_d.st    = X_DAT;
                end
            end
            X_DAT: if (b_done) begin
                x_d.fail = b_fail;
                if (!b_fail && x_q.rnw) x_d.rdata = b_rx;
                x_d.cs_n = 1'b1;
                x_d.cnt  = '0;
                x_d.st   = X_GAP;
            end
            X_GAP: begin
                if (x_q.cnt >= GW'(GAP_CYC - 1)) begin
                    x_d.done = 1'b1;
                    x_d.st   = X_IDLE;
                end else begin
                    x_d.cnt = x_q.cnt + GW'(1);
                end
            end
            default: x_d.st = X_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q      <= '0;
            x_q.st   <= X_IDLE;
            x_q.cs_n <= 1'b1;
        end else begin
            x_q <= x_d;
        end
    end

    assign idle    = (x_q.st == X_IDLE);
    assign xdone   = x_q.done;
    assign xfail   = x_q.fail;
    assign rdata   = x_q.rdata;
    assign cs_n    = x_q.cs_n;
    assign b_start = x_q.start;
    assign b_tx    = x_q.tx;

    // cycles chip select has been high, saturating
    logic [HW-1:0] hi_q;
    always_ff @(posedge clk) begin
        if (!rst_n)             hi_q <= '0;
        else if (!x_q.cs_n)     hi_q <= '0;
        else if (hi_q != '1)    hi_q <= hi_q + HW'(1);
    end

    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_q >= HW'(GAP_CYC))); // R4
    AST_START_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        b_start |-> !cs_n); // R4
    AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        xdone |-> cs_n); // R3
endmodule

// File: rtl/sqc_top.sv
module sqc_top
    import sqc_pkg::*;
#(
    parameter int PRE_WAIT  = 4000,
    parameter int POST_WAIT = 10000,
    parameter int CS_GAP    = 2,
    parameter int MAX_TRIES = 8,
    parameter int BW_W      = 4,
    parameter int BW_LSB    = 4,
    parameter int RG_W      = 3,
    parameter int RG_LSB    = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BW_W-1:0] bw_code,
    input  logic [RG_W-1:0] range_code,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic            spi_cs_n,
    output logic            spi_byte_start,
    output logic [7:0]      spi_byte_tx,
    input  logic            spi_byte_done,
    input  logic            spi_byte_fail,
    input  logic [7:0]      spi_byte_rx
);
    localparam int SW   = $clog2(NUM_STEPS + 1);
    localparam int TW   = $clog2(MAX_TRIES + 1);
    localparam int DMAX = (PRE_WAIT > POST_WAIT) ? PRE_WAIT : POST_WAIT;
    localparam int DW   = $clog2(DMAX + 1);

    typedef enum logic [2:0] { S_IDLE, S_STEP, S_DLY, S_READ, S_WRITE } st_e;

    typedef struct packed {
        st_e             st;
        logic [SW-1:0]   step;
        logic [TW-1:0]   tries;
        logic [BW_W-1:0] bw;
        logic [RG_W-1:0] rng;
        logic            go;
        logic            rnw;
        logic [6:0]      addr;
        logic [7:0]      wdata;
        logic            done;
        logic            err;
    } sreg_t;

    sreg_t s_d, s_q;

    step_t         cur;
    logic          x_idle, x_done, x_fail;
    logic [7:0]    x_rdata;
    logic          t_load, t_zero;
    logic [DW-1:0] t_val;

    sqc_step_rom #(.SW(SW), .BW_W(BW_W), .BW_LSB(BW_LSB), .RG_W(RG_W), .RG_LSB(RG_LSB)) u_rom (
        .idx(s_q.step), .bw(s_q.bw), .rng(s_q.rng), .stp(cur)
    );

    sqc_timer #(.W(DW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .zero(t_zero)
    );

    sqc_xfer #(.GAP_CYC(CS_GAP)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .go(s_q.go), .rnw(s_q.rnw), .addr(s_q.addr), .wdata(s_q.wdata),
        .idle(x_idle), .xdone(x_done), .xfail(x_fail), .rdata(x_rdata),
        .cs_n(spi_cs_n), .b_start(spi_byte_start), .b_tx(spi_byte_tx),
        .b_done(spi_byte_done), .b_fail(spi_byte_fail), .b_rx(spi_byte_rx)
    );

    always_comb begin
        s_d      = s_q;
        s_d.go   = 1'b0;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        t_load   = 1'b0;
        t_val    = (cur.kind == K_WAIT_PRE) ? DW'(PRE_WAIT) : DW'(POST_WAIT);
        case (s_q.st)
            S_IDLE: if (start) begin
                s_d.bw    = bw_code;
                s_d.rng   = range_code;
                s_d.step  = '0;
                s_d.tries = '0;
                s_d.st    = S_STEP;
            end
            S_STEP: begin
                if (s_q.step == SW'(NUM_STEPS)) begin
                    s_d.done = 1'b1;
                    s_d.st   = S_IDLE;
                end else begin
                    case (cur.kind)
                        K_WAIT_PRE, K_WAIT_POST: begin
                            t_load = 1'b1;
                            s_d.st = S_DLY;
                        end
                        K_WRITE: begin
                            s_d.go    = 1'b1;
                            s_d.rnw   = 1'b0;
                            s_d.addr  = cur.addr;
                            s_d.wdata = cur.set;
                            s_d.st    = S_WRITE;
                        end
                        default: begin
                            s_d.go   = 1'b1;
                            s_d.rnw  = 1'b1;
                            s_d.addr = cur.addr;
                            s_d.st   = S_READ;
                        end
                    endcase
                end
            end
            S_DLY: if (t_zero) begin
                s_d.step = s_q.step + SW'(1);
                s_d.st   = S_STEP;
            end
            S_READ, S_WRITE: if (x_done) begin
                if (x_fail) begin
                    if (s_q.tries == TW'(MAX_TRIES - 1)) begin
                        s_d.err = 1'b1;
                        s_d.st  = S_IDLE;
                    end else begin
                        s_d.tries = s_q.tries + TW'(1);
                        s_d.st    = S_STEP;
                    end
                end else if (s_q.st == S_READ) begin
                    s_d.go    = 1'b1;
                    s_d.rnw   = 1'b0;
                    s_d.addr  = cur.addr;
                    s_d.wdata = (x_rdata & ~cur.clr) | (cur.set & cur.clr);
                    s_d.st    = S_WRITE;
                end else begin
                    s_d.step  = s_q.step + SW'(1);
                    s_d.tries = '0;
                    s_d.st    = S_STEP;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st != S_IDLE);
    assign done = s_q.done;
    assign err  = s_q.err;

    AST_GO_TO_IDLE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.go |-> x_idle); // R4
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step != $past(s_q.step)) |-> (s_q.step == $past(s_q.step) + SW'(1) || s_q.step == '0)); // R5
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tries < TW'(MAX_TRIES)); // R10
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R11
    AST_END_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy); // R11
    AST_CODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(s_q.bw) && $stable(s_q.rng))); // R12
endmodule

// File: tb/tb_sqc_top.sv
module tb_sqc_top;
    localparam int PRE   = 40;
    localparam int POST  = 100;
    localparam int GAP   = 3;
    localparam int TRIES = 3;
    localparam int LAT   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] bw_code = '0;
    logic [2:0] range_code = '0;
    logic busy, done, err, spi_cs_n, spi_byte_start;
    logic [7:0] spi_byte_tx;
    logic spi_byte_done = 1'b0, spi_byte_fail = 1'b0;
    logic [7:0] spi_byte_rx = '0;

    always #2.5 clk = ~clk;

    sqc_top #(.PRE_WAIT(PRE), .POST_WAIT(POST), .CS_GAP(GAP), .MAX_TRIES(TRIES)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bw_code(bw_code), .range_code(range_code),
        .busy(busy), .done(done), .err(err), .spi_cs_n(spi_cs_n),
        .spi_byte_start(spi_byte_start), .spi_byte_tx(spi_byte_tx),
        .spi_byte_done(spi_byte_done), .spi_byte_fail(spi_byte_fail), .spi_byte_rx(spi_byte_rx)
    );

    int checks = 0, failures = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // sensor model and bus monitor
    logic [7:0] regs [0:127];
    int wr_a [0:31];
    int wr_v [0:31];
    int wr_cnt, txn_cnt, bad_hdr, byte_cnt, fail_at;
    bit fail_all;
    int cyc, hi_run, min_hi, max_hi, first_fall, start_cyc;
    int idx, lat, cur_addr;
    bit cur_rnw, pend_fail;
    logic [7:0] pend_rx;

    initial begin
        idx = 0; lat = 0; cyc = 0; hi_run = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (spi_cs_n) begin
                idx = 0;
                hi_run++;
            end else begin
                if (hi_run > 0) begin
                    if (first_fall < 0) first_fall = cyc;
                    if (hi_run < min_hi) min_hi = hi_run;
                    if (hi_run > max_hi) max_hi = hi_run;
                end
                hi_run = 0;
            end
            spi_byte_done = 1'b0;
            spi_byte_fail = 1'b0;
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    spi_byte_done = 1'b1;
                    spi_byte_fail = pend_fail;
                    spi_byte_rx   = pend_rx;
                end
            end
            if (spi_byte_start) begin
                pend_fail = fail_all || (byte_cnt == fail_at);
                pend_rx = 8'hFF;
                if (idx == 0) begin
                    txn_cnt++;
                    cur_rnw  = spi_byte_tx[7];
                    cur_addr = int'(spi_byte_tx[6:0]);
                end else if (cur_rnw) begin
                    if (spi_byte_tx != 8'h00) bad_hdr++;
                    pend_rx = regs[cur_addr];
                end else if (!pend_fail) begin
                    regs[cur_addr] = spi_byte_tx;
                    if (wr_cnt < 32) begin
                        wr_a[wr_cnt] = cur_addr;
                        wr_v[wr_cnt] = int'(spi_byte_tx);
                    end
                    wr_cnt++;
                end
                if (idx > 1) bad_hdr++;
                idx++;
                byte_cnt++;
                lat = LAT;
            end
        end
    end

    task automatic prep(input logic [7:0] c0, input logic [7:0] bwr);
        for (int i = 0; i < 128; i++) regs[i] = 8'(i * 37 + 5);
        regs[7'h0D] = c0;
        regs[7'h20] = bwr;
        wr_cnt = 0; txn_cnt = 0; bad_hdr = 0; byte_cnt = 0;
        fail_at = -1; fail_all = 1'b0;
        min_hi = 1000000; max_hi = 0; first_fall = -1;
    endtask

    int n_done, n_err, busy_gap;
    task automatic run(input logic [3:0] bw, input logic [2:0] rg, input bit poke);
        @(negedge clk);
        bw_code = bw; range_code = rg; start = 1'b1; start_cyc = cyc;
        max_hi = 0;
        @(negedge clk);
        start = 1'b0;
        n_done = 0; n_err = 0; busy_gap = 0;
        for (int i = 0; i < 5000; i++) begin
            if (poke && i == 60) begin
                start = 1'b1; bw_code = ~bw; range_code = ~rg;
            end else begin
                start = 1'b0;
            end
            if (done) n_done++;
            if (err) n_err++;
            if (done || err) break;
            if (!busy) busy_gap++;
            @(negedge clk);
        end
        start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done) n_done++;
            if (err) n_err++;
        end
    endtask

    task automatic check_writes(input string tag, input logic [7:0] c0, input logic [7:0] bwr,
                                input logic [3:0] bw, input logic [2:0] rg);
        int ea [0:10];
        int ev [0:10];
        ea = '{'h0D, 'h10, 'h35, 'h33, 'h21, 'h20, 'h35, 'h0D, 'h0D, 'h21, 'h0D};
        ev[0]  = int'(c0 | 8'h10);
        ev[1]  = 'hB6; ev[2] = 'h81; ev[3] = 'h81; ev[4] = 'hFF;
        ev[5]  = int'((bwr & 8'h0F) | {bw, 4'h0});
        ev[6]  = int'((8'h81 & 8'hF1) | {4'h0, rg, 1'b0});
        ev[7]  = int'(c0 & 8'hEF);
        ev[8]  = int'(c0 | 8'h10);
        ev[9]  = 'h02;
        ev[10] = int'(c0 & 8'hEF);
        chk(wr_cnt == 11, {tag, " R5 write count"}, wr_cnt, 11);
        for (int i = 0; i < 11; i++) begin
            chk(wr_a[i] == ea[i], {tag, " R5 R3 write address"}, wr_a[i], ea[i]);
            if (i == 0 || i == 7 || i == 8 || i == 10)
                chk(wr_v[i] == ev[i], {tag, " R6 enable bit"}, wr_v[i], ev[i]);
            else if (i == 5 || i == 6)
                chk(wr_v[i] == ev[i], {tag, " R7 field update"}, wr_v[i], ev[i]);
            else
                chk(wr_v[i] == ev[i], {tag, " R5 write data"}, wr_v[i], ev[i]);
        end
        chk(bad_hdr == 0, {tag, " R2 R3 framing"}, bad_hdr, 0);
        chk(n_done == 1 && n_err == 0, {tag, " R11 one done"}, n_done * 16 + n_err, 16);
        chk(busy_gap == 0, {tag, " R11 busy held"}, busy_gap, 0);
        chk(min_hi >= GAP, {tag, " R4 cs gap"}, min_hi, GAP);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !err, "R1 outputs idle", {busy, done, err}, 0);
        chk(spi_cs_n == 1'b1, "R1 cs high", spi_cs_n, 1);
    endtask

    task automatic t_clean();
        prep(8'h25, 8'h4A);
        run(4'h5, 3'h3, 1'b0);
        check_writes("clean", 8'h25, 8'h4A, 4'h5, 3'h3);
        chk(txn_cnt == 17, "R2 six reads eleven writes", txn_cnt, 17);
        chk(first_fall - start_cyc >= PRE, "R8 pre delay", first_fall - start_cyc, PRE);
        chk(max_hi >= POST, "R8 post delay", max_hi, POST);
        chk(regs[7'h0D] == 8'h25, "R6 final lock", regs[7'h0D], 8'h25);
    endtask

    task automatic t_fields();
        prep(8'hD3, 8'h0F);
        run(4'hF, 3'h7, 1'b0);
        check_writes("fields", 8'hD3, 8'h0F, 4'hF, 3'h7);
        chk(regs[7'h20] == 8'hFF, "R7 bandwidth register", regs[7'h20], 8'hFF);
        chk(regs[7'h35] == 8'h8F, "R7 range register", regs[7'h35], 8'h8F);
    endtask

    task automatic t_retry();
        prep(8'h01, 8'hA5);
        fail_at = 14;
        run(4'h9, 3'h2, 1'b0);
        check_writes("retry", 8'h01, 8'hA5, 4'h9, 3'h2);
        chk(txn_cnt == 19, "R9 step repeated", txn_cnt, 19);
    endtask

    task automatic t_ignore();
        prep(8'h40, 8'h33);
        run(4'h6, 3'h5, 1'b1);
        check_writes("ignore", 8'h40, 8'h33, 4'h6, 3'h5);
        chk(wr_v[5] == 'h63, "R12 sampled bandwidth code", wr_v[5], 'h63);
    endtask

    task automatic t_abort();
        prep(8'h00, 8'h00);
        fail_all = 1'b1;
        run(4'h1, 3'h1, 1'b0);
        chk(n_err == 1 && n_done == 0, "R10 err pulse", n_err * 16 + n_done, 16);
        chk(txn_cnt == TRIES, "R10 attempt count", txn_cnt, TRIES);
        chk(wr_cnt == 0, "R9 failed write no effect", wr_cnt, 0);
        repeat (50) @(negedge clk);
        chk(txn_cnt == TRIES && !busy && spi_cs_n, "R10 stays quiet", txn_cnt, TRIES);
        fail_all = 1'b0;
    endtask

    bit finished = 1'b0;
    initial begin
        prep(8'h00, 8'h00);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_fields();
        t_retry();
        t_ignore();
        t_abort();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule